// File: doc/BRIEF.md
# I2C Engine Ownership Arbiter

This block decides which of three agents may drive a shared I2C bit engine: an autonomous hardware agent, a microcontroller that can lock the engine for itself, and software working through control bits. Each cycle it picks an owner from the requests, keeps that owner while the engine reports busy, and presents the result as a two-bit owner code. The one exception to holding is the hardware agent, which may take the engine away from a running software transfer.

Software claims the engine with a level request bit and gives it up with a done pulse. Its GO pulses are turned into engine start pulses only while software owns the engine. A GO that arrives while hardware owns the engine, or a software transfer that hardware pre-empts, is remembered and reissued automatically once the engine returns to software, unless the no-queue control is set; in that case the GO is rejected. On release the block asks for a status reset, and it asks for a soft reset of the engine only when software held it. The engine enable follows software ownership and, in the gating variant, drops on release.

Top module: `i2c_own_arb`

## Requirements
- R1: After reset the owner code is 0 (idle) and eng_go, go_reject, restart_pend, eng_en, eng_soft_rst and eng_stat_rst are all 0.
- R2: The owner code is 0 idle, 1 software, 2 hardware, 3 microcontroller; with the engine idle, no lock and no hardware request, a software request makes the owner 1 one cycle later.
- R3: While mcu_lock is high and the engine is idle, the owner becomes 3 one cycle later and software is not granted.
- R4: Requests raised in the same cycle are resolved lock first, then hardware, then software.
- R5: While eng_busy is high the owner code does not change, except for a hardware pre-emption of software (R6).
- R6: With software owning a busy engine and no lock, a hardware request makes the owner 2 one cycle later.
- R7: A sw_go pulse while software owns the engine gives a one-cycle eng_go pulse one cycle later.
- R8: A sw_go pulse while hardware owns the engine sets restart_pend when no_queue is 0 (and is launched as in R9), and gives a one-cycle go_reject pulse when no_queue is 1.
- R9: A pre-empted busy software transfer sets restart_pend when no_queue is 0, or pulses go_reject when it is 1; a pending restart issues eng_go one cycle after the owner is back at 1 with the engine idle, and restart_pend then clears.
- R10: A sw_go pulse while the owner is 0 or 3 gives go_reject and no eng_go.
- R11: A sw_done pulse pulses eng_stat_rst one cycle later; eng_soft_rst pulses with it only if the owner was 1 when sw_done was seen.
- R12: eng_en rises one cycle after the owner becomes 1; with KEEP_POWER = 0 it falls on sw_done, with KEEP_POWER = 1 it stays high.
- R13: A sw_done pulse clears restart_pend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 1 | Hardware agent request (level) |
| mcu_lock | input | 1 | Microcontroller exclusive lock (level) |
| sw_req | input | 1 | Software ownership request (level) |
| sw_done | input | 1 | Software done-using pulse |
| sw_go | input | 1 | Software transfer start pulse |
| no_queue | input | 1 | 1: reject GOs that cannot start now instead of queueing them |
| eng_busy | input | 1 | Engine reports a transfer in progress |
| owner | output | 2 | Current owner code |
| eng_go | output | 1 | Start pulse to the engine |
| go_reject | output | 1 | Pulse: a GO or pre-empted transfer was dropped |
| restart_pend | output | 1 | A software transfer waits to be reissued |
| eng_en | output | 1 | Engine enable for software use |
| eng_soft_rst | output | 1 | Engine soft reset pulse |
| eng_stat_rst | output | 1 | Engine status reset pulse |

## Verification
A wrong owner register shows on the owner code the cycle after the requests change, and a wrong hold decision shows as a code change while eng_busy is high. A lost or stuck pending flag appears at restart_pend immediately and as a missing or extra eng_go one cycle after the owner returns to software. Release errors show as a wrong reset pulse pair or a stale eng_en in the cycle after sw_done.

// File: rtl/i2c_own_pkg.sv
package i2c_own_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_SW   = 2'd1,
      OWN_HW   = 2'd2,
      OWN_MCU  = 2'd3
   } own_e;
endpackage

// File: rtl/i2c_own_sel.sv
module i2c_own_sel
   import i2c_own_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hw_req,
   input  logic mcu_lock,
   input  logic sw_req,
   input  logic sw_done,
   input  logic eng_busy,
   output own_e owner_q,
   output logic preempt
);
   own_e cand;
   own_e owner_d;

   always_comb begin
      if (mcu_lock)                 cand = OWN_MCU;
      else if (hw_req)              cand = OWN_HW;
      else if (sw_req && !sw_done)  cand = OWN_SW;
      else                          cand = OWN_IDLE;
   end

   assign preempt = (owner_q == OWN_SW) && hw_req && !mcu_lock && eng_busy;

   always_comb begin
      if (!eng_busy || preempt) owner_d = cand;
      else                      owner_d = owner_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_IDLE;
      else        owner_q <= owner_d;
   end

   // R3
   mcu_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mcu_lock && !eng_busy) |=> (owner_q == OWN_MCU));
   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && owner_q != OWN_SW) |=> $stable(owner_q));
   // R6
   preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_SW && eng_busy && hw_req && !mcu_lock) |=> (owner_q == OWN_HW));
endmodule

// File: rtl/i2c_own_go.sv
module i2c_own_go
   import i2c_own_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  own_e owner_q,
   input  logic sw_go,
   input  logic sw_done,
   input  logic no_queue,
   input  logic preempt,
   input  logic eng_busy,
   output logic eng_go,
   output logic go_reject,
   output logic restart_pend
);
   logic owned, queue_go, launch, reject, pend_d;

   assign owned    = (owner_q == OWN_SW);
   assign queue_go = sw_go && (owner_q == OWN_HW) && !no_queue;
   assign launch   = (sw_go && owned) || (restart_pend && owned && !eng_busy);
   assign reject   = (sw_go && !owned && !queue_go) || (preempt && no_queue);

   always_comb begin
      if (sw_done)                                   pend_d = 1'b0;
      else if ((preempt && !no_queue) || queue_go)   pend_d = 1'b1;
      else if (restart_pend && owned && !eng_busy)   pend_d = 1'b0;
      else                                           pend_d = restart_pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_go       <= 1'b0;
         go_reject    <= 1'b0;
         restart_pend <= 1'b0;
      end else begin
         eng_go       <= launch;
         go_reject    <= reject;
         restart_pend <= pend_d;
      end
   end

   // R7
   go_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> $past(owner_q == OWN_SW));
   // R13
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_done |=> !restart_pend);
endmodule

// File: rtl/i2c_own_pwr.sv
module i2c_own_pwr
   import i2c_own_pkg::*;
#(
   parameter int KEEP_POWER = 0
)(
   input  logic clk,
   input  logic rst_n,
   input  own_e owner_q,
   input  logic sw_done,
   output logic eng_en,
   output logic eng_soft_rst,
   output logic eng_stat_rst
);
   logic en_d;

   generate
      if (KEEP_POWER < 0 || KEEP_POWER > 1) begin : g_bad
         $error("KEEP_POWER must be 0 or 1");
      end
      if (KEEP_POWER == 1) begin : g_keep
         assign en_d = eng_en || (owner_q == OWN_SW);
      end else begin : g_gate
         assign en_d = sw_done ? 1'b0 : (eng_en || (owner_q == OWN_SW));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_en       <= 1'b0;
         eng_soft_rst <= 1'b0;
         eng_stat_rst <= 1'b0;
      end else begin
         eng_en       <= en_d;
         eng_stat_rst <= sw_done;
         eng_soft_rst <= sw_done && (owner_q == OWN_SW);
      end
   end

   // R11
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_soft_rst |-> $past(owner_q == OWN_SW));
   // R11
   stat_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_soft_rst |-> eng_stat_rst);
endmodule

// File: rtl/i2c_own_arb.sv
module i2c_own_arb
   import i2c_own_pkg::*;
#(
   parameter int KEEP_POWER = 0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hw_req,
   input  logic       mcu_lock,
   input  logic       sw_req,
   input  logic       sw_done,
   input  logic       sw_go,
   input  logic       no_queue,
   input  logic       eng_busy,
   output logic [1:0] owner,
   output logic       eng_go,
   output logic       go_reject,
   output logic       restart_pend,
   output logic       eng_en,
   output logic       eng_soft_rst,
   output logic       eng_stat_rst
);
   own_e owner_q;
   logic preempt;

   i2c_own_sel u_sel (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .mcu_lock(mcu_lock),
      .sw_req(sw_req), .sw_done(sw_done), .eng_busy(eng_busy),
      .owner_q(owner_q), .preempt(preempt)
   );

   i2c_own_go u_go (
      .clk(clk), .rst_n(rst_n), .owner_q(owner_q), .sw_go(sw_go),
      .sw_done(sw_done), .no_queue(no_queue), .preempt(preempt),
      .eng_busy(eng_busy), .eng_go(eng_go), .go_reject(go_reject),
      .restart_pend(restart_pend)
   );

   i2c_own_pwr #(.KEEP_POWER(KEEP_POWER)) u_pwr (
      .clk(clk), .rst_n(rst_n), .owner_q(owner_q), .sw_done(sw_done),
      .eng_en(eng_en), .eng_soft_rst(eng_soft_rst), .eng_stat_rst(eng_stat_rst)
   );

   assign owner = owner_q;

   // R10
   no_go_unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_go && owner_q != OWN_SW && !restart_pend) |=> !eng_go);
endmodule

// File: tb/i2c_own_arb_tb.sv
module i2c_own_arb_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hw_req = 0, mcu_lock = 0, sw_req = 0, sw_done = 0, sw_go = 0, no_queue = 0, eng_busy = 0;
   logic [1:0] owner, owner_k;
   logic eng_go, go_reject, restart_pend, eng_en, eng_soft_rst, eng_stat_rst;
   logic go_k, rej_k, pend_k, en_k, srst_k, strst_k;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_own_arb #(.KEEP_POWER(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .mcu_lock(mcu_lock),
      .sw_req(sw_req), .sw_done(sw_done), .sw_go(sw_go), .no_queue(no_queue),
      .eng_busy(eng_busy), .owner(owner), .eng_go(eng_go), .go_reject(go_reject),
      .restart_pend(restart_pend), .eng_en(eng_en), .eng_soft_rst(eng_soft_rst),
      .eng_stat_rst(eng_stat_rst)
   );

   i2c_own_arb #(.KEEP_POWER(1)) u_dut_keep (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .mcu_lock(mcu_lock),
      .sw_req(sw_req), .sw_done(sw_done), .sw_go(sw_go), .no_queue(no_queue),
      .eng_busy(eng_busy), .owner(owner_k), .eng_go(go_k), .go_reject(rej_k),
      .restart_pend(pend_k), .eng_en(en_k), .eng_soft_rst(srst_k),
      .eng_stat_rst(strst_k)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_go();
      sw_go = 1; step(); sw_go = 0;
   endtask

   task automatic pulse_done();
      sw_done = 1; step(); sw_done = 0;
   endtask

   task automatic t_reset();
      chk("R1 owner", owner, 0);
      chk("R1 outs", {eng_go, go_reject, restart_pend, eng_en, eng_soft_rst, eng_stat_rst}, 0);
      chk("R1 keep en", en_k, 0);
   endtask

   task automatic t_claim_go();
      sw_req = 1; step();
      chk("R2 owner sw", owner, 1);
      chk("R12 en not yet", eng_en, 0);
      step();
      chk("R12 en set", eng_en, 1);
      pulse_go();
      chk("R7 go pulse", eng_go, 1);
      step();
      chk("R7 go ends", eng_go, 0);
   endtask

   task automatic t_preempt_restart();
      eng_busy = 1; hw_req = 1; step();
      chk("R6 owner hw", owner, 2);
      chk("R9 pend set", restart_pend, 1);
      eng_busy = 0; no_queue = 1; pulse_go();
      chk("R8 reject", go_reject, 1);
      chk("R8 no go", eng_go, 0);
      no_queue = 0; hw_req = 0; step();
      chk("R9 owner back", owner, 1);
      chk("R9 not yet", eng_go, 0);
      step();
      chk("R9 restart go", eng_go, 1);
      chk("R9 pend clr", restart_pend, 0);
      step();
      chk("R9 single go", eng_go, 0);
   endtask

   task automatic t_preempt_reject();
      eng_busy = 1; no_queue = 1; hw_req = 1; step();
      chk("R9 reject", go_reject, 1);
      chk("R9 no pend", restart_pend, 0);
      eng_busy = 0; hw_req = 0; no_queue = 0; step();
      chk("R9 back sw", owner, 1);
      step();
      chk("R9 no restart", eng_go, 0);
   endtask

   task automatic t_busy_mcu();
      eng_busy = 1; mcu_lock = 1; step();
      chk("R5 hold", owner, 1);
      step();
      chk("R5 hold2", owner, 1);
      eng_busy = 0; step();
      chk("R3 mcu owns", owner, 3);
      pulse_go();
      chk("R10 reject mcu", go_reject, 1);
      chk("R10 no go", eng_go, 0);
      mcu_lock = 0; step();
      chk("R2 back sw", owner, 1);
   endtask

   task automatic t_release_prio();
      sw_req = 0; pulse_done();
      chk("R11 stat rst", eng_stat_rst, 1);
      chk("R11 soft rst", eng_soft_rst, 1);
      chk("R2 idle", owner, 0);
      chk("R12 gate off", eng_en, 0);
      chk("R12 keep on", en_k, 1);
      pulse_go();
      chk("R10 reject idle", go_reject, 1);
      sw_req = 1; hw_req = 1; mcu_lock = 1; step();
      chk("R4 lock first", owner, 3);
      mcu_lock = 0; step();
      chk("R4 hw second", owner, 2);
      hw_req = 0; step();
      chk("R4 sw third", owner, 1);
   endtask

   task automatic t_queue();
      hw_req = 1; step();
      chk("R8 hw owns", owner, 2);
      pulse_go();
      chk("R8 queued", restart_pend, 1);
      chk("R8 no reject", go_reject, 0);
      hw_req = 0; step();
      chk("R8 owner sw", owner, 1);
      step();
      chk("R8 queued go", eng_go, 1);
      hw_req = 1; step();
      pulse_go();
      chk("R13 pend", restart_pend, 1);
      sw_req = 0; pulse_done();
      chk("R13 pend clr", restart_pend, 0);
      chk("R11 stat only", eng_stat_rst, 1);
      chk("R11 no soft", eng_soft_rst, 0);
      hw_req = 0; step();
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      t_reset();
      rst_n = 1; step();
      t_reset();
      t_claim_go();
      t_preempt_restart();
      t_preempt_reject();
      t_busy_mcu();
      t_release_prio();
      t_queue();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule